// File: doc/BRIEF.md
# UART Interrupt Pending and Masking Logic

This block collects the interrupt events of a serial port (receive data available, receive error, transmit space available and modem line change) into a four-bit source-pending register. It combines that register with a four-bit mask and drives a single interrupt line toward the system interrupt controller.

The receive and transmit conditions come from FIFO occupancy counts. Each count is compared against a trigger threshold chosen by a 3-bit code. For each direction, the receive and transmit sources can be configured to follow their condition as a level or to latch only its rising edge. The error and modem sources take single-cycle event strobes.

Software clears pending bits by writing ones, and it programs the mask through the same small write port. The raw view shows every captured event. The masked view shows only the events that can reach the interrupt line.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Bit positions are fixed in every 4-bit vector: receive is bit 0, error is bit 1, transmit is bit 2 and modem is bit 3.
- R2: A write to address 0 (masked view) or address 1 (raw view) clears each source-pending bit whose data bit is 1. Bits written with 0 stay unchanged. Address 3 writes have no effect.
- R3: A write to address 2 loads the mask with the written data, visible on `mask_o` the following cycle. A mask bit of 1 removes its source from `pend_o` and from the interrupt line; a mask bit of 0 lets it through.
- R4: `src_pend_o` shows every captured event regardless of the mask. `pend_o` equals `src_pend_o` with the masked bits forced to 0.
- R5: `irq_o` is the OR of all bits of `pend_o`, registered, so it follows `pend_o` one clock later.
- R6: The receive condition holds when `rx_count` is greater than `(rx_trig * DEPTH) / 8`.
- R7: The transmit condition holds when `tx_count` is less than or equal to `(tx_trig * DEPTH) / 8`.
- R8: With the direction's level-type input at 1, the bit is set on every edge where its condition holds. A clear in the same cycle wins, and the bit sets again at the next edge if the condition still holds.
- R9: With the level-type input at 0, the bit is set only at the edge where the condition rises from false to true. Clearing it while the condition stays true leaves it clear.
- R10: A `rx_err_evt` strobe sets the error bit only while `err_irq_en` is 1. A `modem_evt` strobe always sets the modem bit.
- R11: An edge-type event (receive or transmit rising edge in pulse type, error strobe, modem strobe) that arrives in the same cycle as a clear of its bit leaves the bit set.
- R12: Reset is synchronous and active high. It leaves `src_pend_o`, `mask_o` and `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_trig | input | 3 | Receive trigger code |
| tx_trig | input | 3 | Transmit trigger code |
| rx_level_type | input | 1 | 1: receive source is level type, 0: pulse type |
| tx_level_type | input | 1 | 1: transmit source is level type, 0: pulse type |
| err_irq_en | input | 1 | Lets receive error strobes reach the error bit |
| rx_err_evt | input | 1 | Receive error strobe |
| modem_evt | input | 1 | Modem line change strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0: clear via masked view, 1: clear via raw view, 2: mask, 3: none |
| wr_data | input | 4 | Write data |
| src_pend_o | output | 4 | Raw source-pending bits |
| pend_o | output | 4 | Pending bits after masking |
| mask_o | output | 4 | Mask register |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle: a software clear and a new event for the same bit. The outcome depends on the event type. A level condition loses that cycle and sets the bit again one edge later. An edge-type event survives the clear.

The bench provokes the level case on every step of the threshold sweeps, by clearing all bits in the same cycle that a new FIFO count is applied. It then checks for a zero after the first edge and for the arithmetic threshold result after the second. For the edge-type case, the bench writes the clear in the same cycle as a modem strobe and as a rising receive condition in pulse type, and then expects the bit to read back as 1.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int unsigned NSRC = 4;

    // bit positions shared by every 4-bit vector
    localparam int unsigned SRC_RX  = 0;
    localparam int unsigned SRC_ERR = 1;
    localparam int unsigned SRC_TX  = 2;
    localparam int unsigned SRC_MDM = 3;

    typedef enum logic [1:0] {
        ADDR_CLR_PEND = 2'd0,
        ADDR_CLR_SRC  = 2'd1,
        ADDR_MASK     = 2'd2,
        ADDR_NONE     = 2'd3
    } uirq_addr_e;

    typedef struct packed {
        logic [NSRC-1:0] evt;    // event this cycle
        logic [NSRC-1:0] level;  // 1: clear beats event
    } uirq_evt_t;

    function automatic int unsigned trig_thresh(input logic [2:0] code,
                                                input int unsigned depth);
        return (32'(code) * depth) >> 3;
    endfunction

endpackage

// File: rtl/uirq_fifo_cond.sv
module uirq_fifo_cond #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5,
    parameter bit          IS_TX = 1'b0
) (
    input  logic [CNT_W-1:0] count,
    input  logic [2:0]       code,
    output logic             cond
);
    import uirq_pkg::*;

    int unsigned thr;
    int unsigned cnt32;

    always_comb begin
        thr   = trig_thresh(code, DEPTH);
        cnt32 = 32'(count);
    end

    generate
        if (IS_TX) begin : g_tx
            // space available: occupancy at or under the threshold
            assign cond = (cnt32 <= thr);
        end else begin : g_rx
            // data available: occupancy above the threshold
            assign cond = (cnt32 > thr);
        end
    endgenerate

endmodule

// File: rtl/uirq_evt_gen.sv
module uirq_evt_gen (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic level_mode,
    output logic evt
);
    logic cond_q;

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= cond;
    end

    assign evt = level_mode ? cond : (cond & ~cond_q);

endmodule

// File: rtl/uirq_pend_cell.sv
module uirq_pend_cell (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic level,
    input  logic clr,
    output logic q
);
    logic q_next;

    always_comb begin
        if (level) q_next = (q | evt) & ~clr;   // clear wins, re-sets next edge
        else       q_next = (q & ~clr) | evt;   // new edge survives the clear
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_next;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [2:0]       rx_trig,
    input  logic [2:0]       tx_trig,
    input  logic             rx_level_type,
    input  logic             tx_level_type,
    input  logic             err_irq_en,
    input  logic             rx_err_evt,
    input  logic             modem_evt,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [3:0]       wr_data,
    output logic [3:0]       src_pend_o,
    output logic [3:0]       pend_o,
    output logic [3:0]       mask_o,
    output logic             irq_o
);
    import uirq_pkg::*;

    logic      rx_cond, tx_cond;
    logic      rx_evt, tx_evt;
    uirq_evt_t ev;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] mask_q;
    logic            irq_q;
    uirq_addr_e      addr;

    uirq_fifo_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_cond (
        .count(rx_count), .code(rx_trig), .cond(rx_cond));

    uirq_fifo_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_cond (
        .count(tx_count), .code(tx_trig), .cond(tx_cond));

    uirq_evt_gen u_rx_evt (.clk(clk), .rst(rst), .cond(rx_cond),
                           .level_mode(rx_level_type), .evt(rx_evt));
    uirq_evt_gen u_tx_evt (.clk(clk), .rst(rst), .cond(tx_cond),
                           .level_mode(tx_level_type), .evt(tx_evt));

    always_comb begin
        ev = '0;
        ev.evt[SRC_RX]    = rx_evt;
        ev.evt[SRC_ERR]   = rx_err_evt & err_irq_en;
        ev.evt[SRC_TX]    = tx_evt;
        ev.evt[SRC_MDM]   = modem_evt;
        ev.level[SRC_RX]  = rx_level_type;
        ev.level[SRC_TX]  = tx_level_type;
    end

    assign addr = uirq_addr_e'(wr_addr);

    always_comb begin
        clr_vec = '0;
        if (wr_en && (addr == ADDR_CLR_PEND || addr == ADDR_CLR_SRC))
            clr_vec = wr_data;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_cell
            uirq_pend_cell u_cell (
                .clk(clk), .rst(rst),
                .evt(ev.evt[gi]), .level(ev.level[gi]),
                .clr(clr_vec[gi]), .q(src_q[gi]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                          mask_q <= '0;
        else if (wr_en && addr == ADDR_MASK) mask_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(src_q & ~mask_q);
    end

    assign src_pend_o = src_q;
    assign pend_o     = src_q & ~mask_q;
    assign mask_o     = mask_q;
    assign irq_o      = irq_q;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_level_type,
    input logic       err_irq_en,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [3:0] wr_data,
    input logic [3:0] src_pend_o,
    input logic [3:0] pend_o,
    input logic [3:0] mask_o,
    input logic       irq_o
);
    logic [3:0] clr_seen;
    assign clr_seen = (wr_en && wr_addr < 2'd2) ? wr_data : 4'h0;

    // R5
    irq_lat_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_o == $past(|pend_o));

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2) |=> mask_o == $past(wr_data));

    // R8
    lvl_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_seen[0] && rx_level_type) |=> !src_pend_o[0]);

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(src_pend_o) & ~$past(clr_seen)) & ~src_pend_o) == 4'h0);

    // R10
    err_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_irq_en && !src_pend_o[1]) |=> !src_pend_o[1]);

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .rx_level_type(rx_level_type),
    .err_irq_en(err_irq_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_pend_o(src_pend_o), .pend_o(pend_o),
    .mask_o(mask_o), .irq_o(irq_o));

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] rx_count = '0, tx_count = CNT_W'(DEPTH);
    logic [2:0] rx_trig = '0, tx_trig = '0;
    logic rx_level_type = 1'b1, tx_level_type = 1'b1, err_irq_en = 1'b0;
    logic rx_err_evt = 1'b0, modem_evt = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [3:0] src_pend_o, pend_o, mask_o;
    logic irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_irq_ctrl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .rx_count(rx_count), .tx_count(tx_count),
        .rx_trig(rx_trig), .tx_trig(tx_trig), .rx_level_type(rx_level_type),
        .tx_level_type(tx_level_type), .err_irq_en(err_irq_en),
        .rx_err_evt(rx_err_evt), .modem_evt(modem_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .src_pend_o(src_pend_o),
        .pend_o(pend_o), .mask_o(mask_o), .irq_o(irq_o));

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        wr_en = 1'b0; rx_err_evt = 1'b0; modem_evt = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    initial begin
        int thr;
        logic [3:0] prev_m;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 src", 32'(src_pend_o), 0);
        check("R12 mask", 32'(mask_o), 0);
        check("R12 irq", 32'(irq_o), 0);
        rst = 1'b0;
        step();

        // R6 R8 receive threshold sweep, level type; R1 bit 0
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n <= DEPTH; n++) begin
                @(negedge clk);
                rx_trig = 3'(c); rx_count = CNT_W'(n);
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 4'hF;
                step();
                check("R8 clear wins rx", 32'(src_pend_o[0]), 0);
                step();
                thr = (c * DEPTH) / 8;
                check("R6 rx cond bit0", 32'(src_pend_o), (n > thr) ? 1 : 0);
            end
        end
        rx_count = '0;

        // R7 transmit threshold sweep; R1 bit 2
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n <= DEPTH; n++) begin
                @(negedge clk);
                tx_trig = 3'(c); tx_count = CNT_W'(n);
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 4'hF;
                step();
                check("R8 clear wins tx", 32'(src_pend_o[2]), 0);
                step();
                thr = (c * DEPTH) / 8;
                check("R7 tx cond bit2", 32'(src_pend_o), (n <= thr) ? 4 : 0);
            end
        end
        tx_count = CNT_W'(DEPTH); tx_trig = '0; rx_trig = '0;
        wr(2'd0, 4'hF);

        // R10 error gating and modem strobe; R1 bits 1 and 3
        @(negedge clk); rx_err_evt = 1'b1; step();
        check("R10 err ignored when disabled", 32'(src_pend_o), 0);
        err_irq_en = 1'b1;
        @(negedge clk); rx_err_evt = 1'b1; step();
        check("R10 err sets bit1", 32'(src_pend_o), 4'b0010);
        @(negedge clk); modem_evt = 1'b1; step();
        check("R10 modem sets bit3", 32'(src_pend_o), 4'b1010);

        // R2 write-one-to-clear
        wr(2'd0, 4'h0);
        check("R2 zero write keeps", 32'(src_pend_o), 4'b1010);
        wr(2'd3, 4'hF);
        check("R2 addr3 no effect", 32'(src_pend_o), 4'b1010);
        wr(2'd1, 4'b0010);
        check("R2 raw clear bit1", 32'(src_pend_o), 4'b1000);
        wr(2'd0, 4'b1000);
        check("R2 masked clear bit3", 32'(src_pend_o), 4'b0000);

        // R3 R4 R5 mask sweep with all four pending
        @(negedge clk); rx_err_evt = 1'b1; modem_evt = 1'b1;
        rx_count = CNT_W'(DEPTH); tx_count = '0;
        step(); step();
        check("R1 all four pending", 32'(src_pend_o), 4'hF);
        prev_m = 4'h0;
        for (int m = 0; m < 16; m++) begin
            wr(2'd2, 4'(m));
            check("R3 mask readback", 32'(mask_o), 32'(m));
            check("R4 raw ignores mask", 32'(src_pend_o), 4'hF);
            check("R3 masked view", 32'(pend_o), 32'(4'hF & ~4'(m)));
            check("R5 irq one cycle late", 32'(irq_o), (prev_m != 4'hF) ? 1 : 0);
            step();
            check("R5 irq follows", 32'(irq_o), (m != 15) ? 1 : 0);
            prev_m = 4'(m);
        end
        wr(2'd2, 4'h0);

        // R9 pulse type receive
        rx_level_type = 1'b0; rx_count = '0; tx_count = CNT_W'(DEPTH);
        step();
        wr(2'd0, 4'hF);
        check("R9 idle clear", 32'(src_pend_o), 0);
        @(negedge clk); rx_count = CNT_W'(DEPTH); step();
        check("R9 rising edge sets", 32'(src_pend_o), 1);
        wr(2'd0, 4'b0001);
        check("R9 cleared", 32'(src_pend_o), 0);
        step(); step();
        check("R9 held cond no reset", 32'(src_pend_o), 0);
        @(negedge clk); rx_count = '0; step();
        check("R9 low stays clear", 32'(src_pend_o), 0);

        // R11 edge events coinciding with clear
        @(negedge clk); rx_count = CNT_W'(DEPTH);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 4'b0001;
        step();
        check("R11 rx edge beats clear", 32'(src_pend_o), 1);
        @(negedge clk); modem_evt = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 4'b1001;
        step();
        check("R11 modem beats clear", 32'(src_pend_o), 4'b1000);
        step();
        check("R5 irq from modem", 32'(irq_o), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule